// File: doc/BRIEF.md
# Network Channel Stop Sequencer

This block carries out a host stop command on the transmit or receive side of a DMA-driven network adapter. The host writes a command word. One bit requests a stop, one bit picks the direction, and a third bit restarts a direction. A stop does not reset the direction at once. The block first waits until the bus master reports that the transfer in flight has reached a safe boundary: the end of a data fragment, of a list, or of the completion-status DMA. Only then does it hold that direction's FIFO control and network state machines in reset.

When the hold is applied, a sticky stopped flag is raised for that direction. This happens only if the direction had an active channel when the command arrived. A direction that was already idle is still put in reset, but its flag stays low. A frame whose DMA completes while the stop is pending still delivers its frame interrupt and its end-of-channel interrupt. Once the hold is in force, those interrupts and the receive statistics increments are blocked. The hold lasts until the host sends a restart for that direction, which also clears the flag. The flags can be cleared separately by a write-one-to-clear.

Top module: `chan_halt_seq`

## Requirements
- R1: A command write with bit 30 (stop) set and bit 29 (direction) at 0 stops the transmit side (index 0 of every per-direction port); with bit 29 at 1 it stops the receive side (index 1); the other side is untouched.
- R2: The command is registered at the clock edge where `cmd_wr` is high; at each following edge while the stop is pending, the hold is applied if that direction's `xfer_busy` is low or its `xfer_bdry` is high, so `fsm_rst_hold` rises one cycle after the boundary (or after the command when the bus is not busy) and stays low while the transfer is busy without a boundary.
- R3: When the hold is applied and the direction had an active channel at the command edge, `stopped_flags` bit 0 (transmit) or bit 1 (receive) is set in the same cycle in which the hold rises.
- R4: When the direction was idle at the command edge (all `tx_ch_idle` bits high, or `rx_ch_idle` high), the hold is still applied but the stopped flag is not set.
- R5: `frm_irq_out` and `eoc_irq_out` follow their inputs while a direction is running or its stop is pending, and are forced low while its hold is applied.
- R6: `rx_stat_inc` follows `rx_stat_evt` except while the receive hold is applied, when it stays low.
- R7: A command write with bit 30 clear starts no stop; `cmd_rdata` returns the last written command word with bit 30 and bit 31 always read as 0.
- R8: A command write with bit 31 (restart) set and bit 30 clear, for the direction in bit 29, releases that direction's hold, cancels a pending stop and clears its stopped flag at the next edge.
- R9: A `sts_clr_wr` write with bit d of `sts_clr_data` set clears stopped flag d; if the flag is being set in the same cycle, the set wins.
- R10: A stop for a direction whose stop is already pending merges with it: the hold timing is not restarted and the activity recorded by the first command is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host command write strobe |
| cmd_wdata | input | CMD_W | Command word (bit 31 restart, bit 30 stop, bit 29 direction) |
| cmd_rdata | output | CMD_W | Last command word with stop and restart bits read as 0 |
| sts_clr_wr | input | 1 | Stopped-flag clear strobe |
| sts_clr_data | input | 2 | Write-one-to-clear mask, bit 0 transmit, bit 1 receive |
| tx_ch_idle | input | NUM_TX_CH | Per transmit channel idle indication |
| rx_ch_idle | input | 1 | Receive channel idle indication |
| xfer_busy | input | 2 | Bus transfer in flight, per direction |
| xfer_bdry | input | 2 | Safe transfer boundary reached, per direction |
| frm_irq_in | input | 2 | Frame-complete interrupt from DMA, per direction |
| eoc_irq_in | input | 2 | End-of-channel interrupt from DMA, per direction |
| rx_stat_evt | input | 1 | Receive statistics event |
| frm_irq_out | output | 2 | Gated frame-complete interrupt |
| eoc_irq_out | output | 2 | Gated end-of-channel interrupt |
| rx_stat_inc | output | 1 | Gated receive statistics increment |
| fsm_rst_hold | output | 2 | Reset hold for FIFO control and state machines, per direction |
| stopped_flags | output | 2 | Sticky stopped flags, bit 0 transmit, bit 1 receive |

## Verification
The bench builds the block with three transmit channels and the default 32-bit command word. This allows a transmit stop to be issued with only some channels idle, which must still count as active, as well as with all of them idle. Stops are issued with the bus idle, in the middle of a multi-cycle fragment, and while a last-list frame delivers its frame and end-of-channel interrupts during the pending window. Merged stops, restarts and a flag clear that coincides with a flag set are also covered. A behavioural model is compared against every output on every cycle.

// File: rtl/chan_halt_pkg.sv
`timescale 1ns/1ps
package chan_halt_pkg;
  typedef enum logic [1:0] {
    HS_RUN  = 2'd0,
    HS_PEND = 2'd1,
    HS_HALT = 2'd2
  } halt_st_e;

  localparam int NDIR   = 2;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;

  // A pending stop may take effect when nothing is in flight or the
  // transfer in flight has just reached a safe boundary.
  function automatic logic boundary_ok(input logic busy, input logic bdry);
    return !busy || bdry;
  endfunction

  function automatic logic dir_match(input logic sel, input int dir);
    return (sel == dir[0]);
  endfunction
endpackage

// File: rtl/halt_cmd_decode.sv
`timescale 1ns/1ps
module halt_cmd_decode
  import chan_halt_pkg::*;
#(
  parameter int CMD_W    = 32,
  parameter int GO_POS   = 31,
  parameter int STOP_POS = 30,
  parameter int DIR_POS  = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic [NDIR-1:0]  stop_req,
  output logic [NDIR-1:0]  go_req,
  output logic [CMD_W-1:0] cmd_rdata
);
  localparam logic [CMD_W-1:0] SELF_CLR_MASK =
    (CMD_W'(1) << STOP_POS) | (CMD_W'(1) << GO_POS);

  logic stop_bit, go_bit, dir_bit;
  assign stop_bit = cmd_wdata[STOP_POS];
  assign go_bit   = cmd_wdata[GO_POS];
  assign dir_bit  = cmd_wdata[DIR_POS];

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign stop_req[d] = cmd_wr && stop_bit && dir_match(dir_bit, d);
    assign go_req[d]   = cmd_wr && go_bit && !stop_bit && dir_match(dir_bit, d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_rdata <= '0;
    else if (cmd_wr) cmd_rdata <= cmd_wdata & ~SELF_CLR_MASK;
  end
endmodule

// File: rtl/halt_dir_fsm.sv
`timescale 1ns/1ps
module halt_dir_fsm
  import chan_halt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic go_req,
  input  logic active,
  input  logic bus_busy,
  input  logic bus_bdry,
  input  logic flag_clr,
  output logic hold,
  output logic pend,
  output logic enter_halt,
  output logic flag
);
  halt_st_e st_q;
  logic     act_q;

  assign pend       = (st_q == HS_PEND);
  assign hold       = (st_q == HS_HALT);
  assign enter_halt = pend && !go_req && boundary_ok(bus_busy, bus_bdry);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= HS_RUN;
      act_q <= 1'b0;
    end else begin
      unique case (st_q)
        HS_RUN: if (stop_req) begin
          st_q  <= HS_PEND;
          act_q <= active;
        end
        HS_PEND: begin
          if (go_req)          st_q <= HS_RUN;
          else if (enter_halt) st_q <= HS_HALT;
        end
        HS_HALT: if (go_req) st_q <= HS_RUN;
        default: st_q <= HS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     flag <= 1'b0;
    else if (enter_halt && act_q)   flag <= 1'b1;
    else if (go_req || flag_clr)    flag <= 1'b0;
  end
endmodule

// File: rtl/halt_gate.sv
`timescale 1ns/1ps
module halt_gate #(
  parameter int W = 1
) (
  input  logic         hold,
  input  logic [W-1:0] sig_in,
  output logic [W-1:0] sig_out
);
  assign sig_out = hold ? '0 : sig_in;
endmodule

// File: rtl/chan_halt_seq.sv
`timescale 1ns/1ps
module chan_halt_seq
  import chan_halt_pkg::*;
#(
  parameter int CMD_W     = 32,
  parameter int NUM_TX_CH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_wr,
  input  logic [CMD_W-1:0]     cmd_wdata,
  output logic [CMD_W-1:0]     cmd_rdata,
  input  logic                 sts_clr_wr,
  input  logic [1:0]           sts_clr_data,
  input  logic [NUM_TX_CH-1:0] tx_ch_idle,
  input  logic                 rx_ch_idle,
  input  logic [1:0]           xfer_busy,
  input  logic [1:0]           xfer_bdry,
  input  logic [1:0]           frm_irq_in,
  input  logic [1:0]           eoc_irq_in,
  input  logic                 rx_stat_evt,
  output logic [1:0]           frm_irq_out,
  output logic [1:0]           eoc_irq_out,
  output logic                 rx_stat_inc,
  output logic [1:0]           fsm_rst_hold,
  output logic [1:0]           stopped_flags
);
  // named internal events, observed by the bound checker
  logic [NDIR-1:0] stop_req_w;
  logic [NDIR-1:0] go_req_w;
  logic [NDIR-1:0] pend_w;
  logic [NDIR-1:0] enter_halt_w;
  logic [NDIR-1:0] dir_active_w;

  assign dir_active_w[DIR_TX] = !(&tx_ch_idle);
  assign dir_active_w[DIR_RX] = !rx_ch_idle;

  halt_cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .stop_req  (stop_req_w),
    .go_req    (go_req_w),
    .cmd_rdata (cmd_rdata)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    halt_dir_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .stop_req   (stop_req_w[d]),
      .go_req     (go_req_w[d]),
      .active     (dir_active_w[d]),
      .bus_busy   (xfer_busy[d]),
      .bus_bdry   (xfer_bdry[d]),
      .flag_clr   (sts_clr_wr && sts_clr_data[d]),
      .hold       (fsm_rst_hold[d]),
      .pend       (pend_w[d]),
      .enter_halt (enter_halt_w[d]),
      .flag       (stopped_flags[d])
    );

    halt_gate #(.W(2)) u_irq_gate (
      .hold    (fsm_rst_hold[d]),
      .sig_in  ({eoc_irq_in[d], frm_irq_in[d]}),
      .sig_out ({eoc_irq_out[d], frm_irq_out[d]})
    );
  end

  halt_gate #(.W(1)) u_stat_gate (
    .hold    (fsm_rst_hold[DIR_RX]),
    .sig_in  (rx_stat_evt),
    .sig_out (rx_stat_inc)
  );
endmodule

// File: rtl/chan_halt_chk.sv
`timescale 1ns/1ps
module chan_halt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] stop_req,
  input logic [1:0] go_req,
  input logic [1:0] pend,
  input logic [1:0] hold,
  input logic [1:0] flags,
  input logic [1:0] busy,
  input logic [1:0] bdry,
  input logic [1:0] frm_out,
  input logic [1:0] eoc_out,
  input logic       stat_inc
);
  for (genvar d = 0; d < 2; d++) begin : g_d
    // R1: a stop on a running direction enters the pending phase
    a_r1_stop_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req[d] && !pend[d] && !hold[d]) |=> pend[d]);
    // R2: no hold while the transfer is busy without a boundary
    a_r2_wait_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[d] && busy[d] && !bdry[d] && !go_req[d]) |=> (!hold[d] && pend[d]));
    a_r2_hold_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[d] && (!busy[d] || bdry[d]) && !go_req[d]) |=> hold[d]);
    // R3: the flag only rises together with the hold
    a_r3_flag_with_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[d]) |-> hold[d]);
    // R5: interrupts blocked while held
    a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      hold[d] |-> (!frm_out[d] && !eoc_out[d]));
    // R8: restart releases the hold
    a_r8_go_release: assert property (@(posedge clk) disable iff (!rst_n)
      go_req[d] |=> (!hold[d] && !pend[d] && !flags[d]));
    // R10: a second stop while pending does not fall back to running
    a_r10_merge: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[d] && stop_req[d]) |=> (pend[d] || hold[d]));
  end

  // R6: no receive statistics while the receiver is held
  a_r6_no_rx_stats: assert property (@(posedge clk) disable iff (!rst_n)
    hold[1] |-> !stat_inc);
endmodule

bind chan_halt_seq chan_halt_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stop_req (stop_req_w),
  .go_req   (go_req_w),
  .pend     (pend_w),
  .hold     (fsm_rst_hold),
  .flags    (stopped_flags),
  .busy     (xfer_busy),
  .bdry     (xfer_bdry),
  .frm_out  (frm_irq_out),
  .eoc_out  (eoc_irq_out),
  .stat_inc (rx_stat_inc)
);

// File: tb/tb_chan_halt_seq.sv
`timescale 1ns/1ps
module tb_chan_halt_seq;
  localparam int CMD_W = 32;
  localparam int NTX   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [CMD_W-1:0] cmd_wdata = '0;
  logic [CMD_W-1:0] cmd_rdata;
  logic sts_clr_wr = 1'b0;
  logic [1:0] sts_clr_data = '0;
  logic [NTX-1:0] tx_ch_idle = '0;
  logic rx_ch_idle = 1'b0;
  logic [1:0] xfer_busy = '0, xfer_bdry = '0, frm_irq_in = '0, eoc_irq_in = '0;
  logic rx_stat_evt = 1'b0;
  logic [1:0] frm_irq_out, eoc_irq_out, fsm_rst_hold, stopped_flags;
  logic rx_stat_inc;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  chan_halt_seq #(.CMD_W(CMD_W), .NUM_TX_CH(NTX)) dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: per direction 0 running, 1 pending, 2 halted
  int ms[2], ma[2], mf[2];
  logic [CMD_W-1:0] mrd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin ms[d] = 0; ma[d] = 0; mf[d] = 0; end
      mrd = '0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        bit stp, go, clr, ent, act;
        stp = cmd_wr && cmd_wdata[30] && (cmd_wdata[29] == d[0]);
        go  = cmd_wr && cmd_wdata[31] && !cmd_wdata[30] && (cmd_wdata[29] == d[0]);
        clr = sts_clr_wr && sts_clr_data[d];
        act = (d == 0) ? (tx_ch_idle != '1) : !rx_ch_idle;
        ent = 0;
        if (ms[d] == 0) begin
          if (stp) begin ms[d] = 1; ma[d] = act; end
        end else if (ms[d] == 1) begin
          if (go) ms[d] = 0;
          else if (!xfer_busy[d] || xfer_bdry[d]) begin ms[d] = 2; ent = 1; end
        end else if (go) ms[d] = 0;
        if (ent && ma[d] != 0) mf[d] = 1;
        else if (go || clr) mf[d] = 0;
      end
      if (cmd_wr) mrd = cmd_wdata & ~(32'h3 << 30);
    end
    #1;
    if (rst_n) begin
      for (int d = 0; d < 2; d++) begin
        chk(fsm_rst_hold[d] == (ms[d] == 2), d ? "R2 rx hold" : "R2 tx hold", fsm_rst_hold[d], ms[d] == 2);
        chk(stopped_flags[d] == (mf[d] != 0), "R3/R4/R9 flag", stopped_flags[d], mf[d]);
        chk(frm_irq_out[d] == (frm_irq_in[d] && ms[d] != 2), "R5 frame irq", frm_irq_out[d], frm_irq_in[d] && ms[d] != 2);
        chk(eoc_irq_out[d] == (eoc_irq_in[d] && ms[d] != 2), "R5 eoc irq", eoc_irq_out[d], eoc_irq_in[d] && ms[d] != 2);
      end
      chk(rx_stat_inc == (rx_stat_evt && ms[1] != 2), "R6 rx stats", rx_stat_inc, rx_stat_evt && ms[1] != 2);
      chk(cmd_rdata == mrd, "R7 readback", cmd_rdata, mrd);
    end
  end

  function automatic logic [CMD_W-1:0] mk(input bit go, input bit stop, input bit dir);
    return ({go, stop, dir} << 29) | 32'h0000_0a5c;
  endfunction

  task automatic cmd(input logic [CMD_W-1:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fsm_rst_hold == 2'b00 && stopped_flags == 2'b00 && cmd_rdata == '0, "R1 reset state", {fsm_rst_hold, stopped_flags}, 0);
    rst_n = 1'b1;

    // tx stop, bus idle, channels partly busy (one not idle)
    tx_ch_idle = 3'b011;
    cmd(mk(0, 1, 0));
    chk(fsm_rst_hold[0] == 1'b0, "R2 not before boundary edge", fsm_rst_hold[0], 0);
    after_edge();
    chk(fsm_rst_hold == 2'b01, "R1 tx only held", fsm_rst_hold, 2'b01);
    chk(stopped_flags == 2'b01, "R3 tx flag", stopped_flags, 2'b01);
    chk(cmd_rdata[31:29] == 3'b000, "R7 stop bit reads 0", cmd_rdata[31:29], 0);
    @(negedge clk); frm_irq_in = 2'b01; eoc_irq_in = 2'b01; #1;
    chk(frm_irq_out[0] == 0 && eoc_irq_out[0] == 0, "R5 held irq blocked", {eoc_irq_out[0], frm_irq_out[0]}, 0);
    @(negedge clk); frm_irq_in = 0; eoc_irq_in = 0;
    cmd(mk(1, 0, 0));
    chk(fsm_rst_hold[0] == 0 && stopped_flags[0] == 0, "R8 restart", {fsm_rst_hold[0], stopped_flags[0]}, 0);

    // rx stop in mid fragment, with merge
    xfer_busy = 2'b10;
    cmd(mk(0, 1, 1));
    rx_stat_evt = 1'b1;
    repeat (2) after_edge();
    chk(fsm_rst_hold[1] == 0 && rx_stat_inc == 1, "R2 waits during fragment", {fsm_rst_hold[1], rx_stat_inc}, 1);
    rx_ch_idle = 1'b1; // a second stop must keep the recorded activity
    cmd(mk(0, 1, 1));
    chk(fsm_rst_hold[1] == 0, "R10 merged, still pending", fsm_rst_hold[1], 0);
    @(negedge clk); xfer_bdry = 2'b10;
    @(negedge clk); xfer_bdry = 0; xfer_busy = 0;
    chk(fsm_rst_hold[1] == 1, "R2 hold after boundary", fsm_rst_hold[1], 1);
    chk(stopped_flags[1] == 1, "R10 first activity kept", stopped_flags[1], 1);
    chk(rx_stat_inc == 0, "R6 stats gated", rx_stat_inc, 0);
    rx_stat_evt = 0; rx_ch_idle = 0;
    @(negedge clk); sts_clr_wr = 1; sts_clr_data = 2'b10;
    @(negedge clk); sts_clr_wr = 0; sts_clr_data = 0;
    chk(stopped_flags[1] == 0 && fsm_rst_hold[1] == 1, "R9 w1c keeps hold", {stopped_flags[1], fsm_rst_hold[1]}, 1);
    cmd(mk(1, 0, 1));

    // tx stop while the last-list frame completes
    tx_ch_idle = 3'b000; xfer_busy = 2'b01;
    cmd(mk(0, 1, 0));
    frm_irq_in = 2'b01; eoc_irq_in = 2'b01; #1;
    chk(frm_irq_out[0] == 1 && eoc_irq_out[0] == 1, "R5 eoc passes while pending", {eoc_irq_out[0], frm_irq_out[0]}, 3);
    @(negedge clk); frm_irq_in = 0; eoc_irq_in = 0; xfer_bdry = 2'b01;
    // clear and set in the same cycle: set wins
    sts_clr_wr = 1; sts_clr_data = 2'b01;
    @(negedge clk); xfer_bdry = 0; xfer_busy = 0; sts_clr_wr = 0; sts_clr_data = 0;
    chk(stopped_flags[0] == 1 && fsm_rst_hold[0] == 1, "R9 set beats clear", {stopped_flags[0], fsm_rst_hold[0]}, 3);
    cmd(mk(1, 0, 0));

    // stop on an idle direction
    tx_ch_idle = 3'b111;
    cmd(mk(0, 1, 0));
    after_edge();
    chk(fsm_rst_hold[0] == 1 && stopped_flags[0] == 0, "R4 idle: hold, no flag", {fsm_rst_hold[0], stopped_flags[0]}, 2);
    cmd(mk(1, 0, 0));

    // stop bit clear: no effect
    tx_ch_idle = 0;
    cmd(32'h2000_1234);
    repeat (3) after_edge();
    chk(fsm_rst_hold == 0 && stopped_flags == 0, "R7 stop bit 0 no effect", {fsm_rst_hold, stopped_flags}, 0);
    chk(cmd_rdata == 32'h2000_1234, "R7 readback word", cmd_rdata, 32'h2000_1234);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule